// File: doc/BRIEF.md
# Halt Mode Entry and Release Controller

This block sits beside a small processor core and decides whether a decoded halt instruction really stops the core, and how the core resumes afterwards. When the decoder raises the halt strobe, the block looks at the 4-bit operand and checks the entry conditions for the requested wake mode. If the operand is illegal or the conditions fail, the halt is turned into a NOP and the core carries on at once. If the checks pass, the block enters the halted state and stays there until a wake event occurs.

Two wake modes exist. In timer-wake mode only an enabled timer interrupt request ends the halt. In key-wake mode an enabled interrupt request from any source ends it, and so does a key pin reaching its release level. Fixed key pins release on a low level. Programmable key pins release on a per-pin level. When the halt ends, the block gives a one-cycle resume pulse. A vector bit on that pulse tells the core either to branch to the interrupt vector or to continue with the next instruction. The bit depends on the global interrupt enable and on which event caused the wake.

Top module: `halt_ctrl`

## Requirements
- R1: After reset `halted`, `resume_pulse`, `resume_vector`, `halt_nop` and `illegal_op` are all 0.
- R2: A strobe with an operand other than 4'b0010 (timer wake) or 4'b1000 (key wake) pulses `halt_nop` and `illegal_op` for one cycle, and `halted` stays 0.
- R3: A strobe with operand 4'b0010 is refused when any `tmr_req` bit is 1, whatever `tmr_en` holds. A refused strobe pulses `halt_nop` with `illegal_op` at 0.
- R4: A strobe with operand 4'b1000 is refused when any request bit (timer or other source) is 1 while its own enable bit is 1. A pending request whose enable bit is 0 does not block entry.
- R5: A strobe with operand 4'b1000 is refused when any key pin whose use bit is 1 sits at its release level. The release level is low for fixed pins and equals `kp_level` for programmable pins. Pins whose use bit is 0 are ignored.
- R6: An accepted strobe sets `halted` on the clock edge that samples it, and `halt_nop` stays 0.
- R7: In key-wake mode, a used key pin reaching its release level ends the halt with `resume_vector` = 0, whatever the value of `gie`.
- R8: A pending request whose enable bit is 0 never ends a halt.
- R9: An enabled request ends a halt. `resume_vector` equals `gie` on the edge that ends it. When a key release and an enabled request occur together, the interrupt rule decides the vector bit.
- R10: In timer-wake mode, key pins and requests from other sources do not end the halt. Only an enabled `tmr_req` bit does.
- R11: `resume_pulse` is high for exactly one cycle, and `halted` is 0 in that same cycle.
- R12: Strobes that arrive while `halted` is 1 are ignored: no NOP, no illegal flag, and no change of mode.
- R13: Key pins pass through a two-flop synchronizer. A key release driven before edge 1 ends the halt on edge 3. Entry checks also use the synchronized values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| halt_strobe | input | 1 | Decoded halt instruction, one cycle |
| halt_operand | input | 4 | Halt operand selecting the wake mode |
| tmr_req | input | N_TMR | Timer interrupt request flags |
| tmr_en | input | N_TMR | Per-flag timer interrupt enables |
| src_req | input | N_SRC | Other interrupt request flags |
| src_en | input | N_SRC | Per-source interrupt enables |
| gie | input | 1 | Global interrupt enable (1 = EI, 0 = DI) |
| kf_in | input | N_KF | Fixed key pins (release on low) |
| kf_used | input | N_KF | Fixed key pin is an input in use |
| kp_in | input | N_KP | Programmable key pins |
| kp_used | input | N_KP | Programmable key pin is an input in use |
| kp_level | input | N_KP | Release level per programmable pin |
| halted | output | 1 | Core clock is stopped |
| resume_pulse | output | 1 | One-cycle wake indication |
| resume_vector | output | 1 | With resume_pulse: 1 = branch to vector, 0 = next instruction |
| halt_nop | output | 1 | One-cycle pulse: the strobe was treated as a NOP |
| illegal_op | output | 1 | One-cycle pulse: the operand was prohibited |

## Verification
Every output is registered, so the result of a strobe or of an interrupt request is due right after the first rising edge that samples it. A key pin change needs three edges: two in the synchronizer and one in the state register. The bench drives inputs on falling edges and samples right after the matching rising edge. For key stimulus it also checks after the second edge, to confirm the halt has not ended early. Before every table strobe, the key levels are held for three cycles so that entry decisions see settled synchronized values.

// File: rtl/halt_pkg.sv
package halt_pkg;
  localparam int OP_W = 4;
  localparam logic [OP_W-1:0] OP_TIMER_WAKE = 4'b0010;
  localparam logic [OP_W-1:0] OP_KEY_WAKE   = 4'b1000;

  typedef enum logic {
    MODE_TIMER = 1'b0,
    MODE_KEY   = 1'b1
  } halt_mode_e;
endpackage

// File: rtl/halt_sync.sv
module halt_sync #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d;
      sync_q <= meta_q;
    end
  end

  assign q = sync_q;
endmodule

// File: rtl/halt_cond.sv
module halt_cond
  import halt_pkg::*;
#(
  parameter int N_TMR = 2,
  parameter int N_SRC = 3,
  parameter int N_KF  = 8,
  parameter int N_KP  = 4
) (
  input  logic [OP_W-1:0]  op,
  input  logic [N_TMR-1:0] tmr_req,
  input  logic [N_TMR-1:0] tmr_en,
  input  logic [N_SRC-1:0] src_req,
  input  logic [N_SRC-1:0] src_en,
  input  logic [N_KF-1:0]  kf_sync,
  input  logic [N_KF-1:0]  kf_used,
  input  logic [N_KP-1:0]  kp_sync,
  input  logic [N_KP-1:0]  kp_used,
  input  logic [N_KP-1:0]  kp_level,
  output logic             op_legal,
  output logic             op_is_key,
  output logic             entry_ok,
  output logic             key_release,
  output logic             timer_wake,
  output logic             irq_wake
);
  // A used fixed pin releases when it reads low.
  function automatic logic fixed_rel(input logic [N_KF-1:0] pins,
                                     input logic [N_KF-1:0] used);
    return |(~pins & used);
  endfunction

  // A used programmable pin releases when it matches its level.
  function automatic logic prog_rel(input logic [N_KP-1:0] pins,
                                    input logic [N_KP-1:0] used,
                                    input logic [N_KP-1:0] lvl);
    return |(~(pins ^ lvl) & used);
  endfunction

  function automatic logic any_enabled_t(input logic [N_TMR-1:0] req,
                                         input logic [N_TMR-1:0] en);
    return |(req & en);
  endfunction

  function automatic logic any_enabled_s(input logic [N_SRC-1:0] req,
                                         input logic [N_SRC-1:0] en);
    return |(req & en);
  endfunction

  logic op_is_timer;
  logic timer_entry_ok;
  logic key_entry_ok;

  always_comb begin
    op_is_timer    = (op == OP_TIMER_WAKE);
    op_is_key      = (op == OP_KEY_WAKE);
    op_legal       = op_is_timer || op_is_key;
    key_release    = fixed_rel(kf_sync, kf_used) ||
                     prog_rel(kp_sync, kp_used, kp_level);
    timer_wake     = any_enabled_t(tmr_req, tmr_en);
    irq_wake       = timer_wake || any_enabled_s(src_req, src_en);
    timer_entry_ok = (tmr_req == '0);
    key_entry_ok   = !irq_wake && !key_release;
    entry_ok       = op_is_key ? key_entry_ok : timer_entry_ok;
  end
endmodule

// File: rtl/halt_fsm.sv
module halt_fsm
  import halt_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic strobe,
  input  logic op_legal,
  input  logic op_is_key,
  input  logic entry_ok,
  input  logic key_release,
  input  logic timer_wake,
  input  logic irq_wake,
  input  logic gie,
  output logic halted,
  output logic mode_key,
  output logic resume_pulse,
  output logic resume_vector,
  output logic halt_nop,
  output logic illegal_op,
  output logic halt_accept,
  output logic wake_now
);
  halt_mode_e mode_q;
  logic       halted_q;
  logic       strobe_live;
  logic       intr_cause;

  always_comb begin
    strobe_live = strobe && !halted_q;
    halt_accept = strobe_live && op_legal && entry_ok;
    intr_cause  = (mode_q == MODE_KEY) ? irq_wake : timer_wake;
    wake_now    = halted_q &&
                  ((mode_q == MODE_KEY) ? (irq_wake || key_release) : timer_wake);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      halted_q      <= 1'b0;
      mode_q        <= MODE_TIMER;
      resume_pulse  <= 1'b0;
      resume_vector <= 1'b0;
      halt_nop      <= 1'b0;
      illegal_op    <= 1'b0;
    end else begin
      if (halt_accept) begin
        halted_q <= 1'b1;
        mode_q   <= op_is_key ? MODE_KEY : MODE_TIMER;
      end else if (wake_now) begin
        halted_q <= 1'b0;
      end
      resume_pulse  <= wake_now;
      resume_vector <= wake_now && intr_cause && gie;
      halt_nop      <= strobe_live && !halt_accept;
      illegal_op    <= strobe_live && !op_legal;
    end
  end

  assign halted   = halted_q;
  assign mode_key = (mode_q == MODE_KEY);
endmodule

// File: rtl/halt_ctrl.sv
module halt_ctrl
  import halt_pkg::*;
#(
  parameter int N_TMR = 2,
  parameter int N_SRC = 3,
  parameter int N_KF  = 8,
  parameter int N_KP  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             halt_strobe,
  input  logic [3:0]       halt_operand,
  input  logic [N_TMR-1:0] tmr_req,
  input  logic [N_TMR-1:0] tmr_en,
  input  logic [N_SRC-1:0] src_req,
  input  logic [N_SRC-1:0] src_en,
  input  logic             gie,
  input  logic [N_KF-1:0]  kf_in,
  input  logic [N_KF-1:0]  kf_used,
  input  logic [N_KP-1:0]  kp_in,
  input  logic [N_KP-1:0]  kp_used,
  input  logic [N_KP-1:0]  kp_level,
  output logic             halted,
  output logic             resume_pulse,
  output logic             resume_vector,
  output logic             halt_nop,
  output logic             illegal_op
);
  localparam int N_KEYS = N_KF + N_KP;

  logic [N_KEYS-1:0] keys_sync;
  logic [N_KF-1:0]   kf_sync;
  logic [N_KP-1:0]   kp_sync;
  logic op_legal, op_is_key, entry_ok;
  logic key_release, timer_wake, irq_wake;
  logic mode_key, halt_accept, wake_now;

  halt_sync #(.W(N_KEYS)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({kp_in, kf_in}),
    .q     (keys_sync)
  );

  assign kf_sync = keys_sync[N_KF-1:0];
  assign kp_sync = keys_sync[N_KEYS-1:N_KF];

  halt_cond #(
    .N_TMR(N_TMR), .N_SRC(N_SRC), .N_KF(N_KF), .N_KP(N_KP)
  ) u_cond (
    .op          (halt_operand),
    .tmr_req     (tmr_req),
    .tmr_en      (tmr_en),
    .src_req     (src_req),
    .src_en      (src_en),
    .kf_sync     (kf_sync),
    .kf_used     (kf_used),
    .kp_sync     (kp_sync),
    .kp_used     (kp_used),
    .kp_level    (kp_level),
    .op_legal    (op_legal),
    .op_is_key   (op_is_key),
    .entry_ok    (entry_ok),
    .key_release (key_release),
    .timer_wake  (timer_wake),
    .irq_wake    (irq_wake)
  );

  halt_fsm u_fsm (
    .clk           (clk),
    .rst_n         (rst_n),
    .strobe        (halt_strobe),
    .op_legal      (op_legal),
    .op_is_key     (op_is_key),
    .entry_ok      (entry_ok),
    .key_release   (key_release),
    .timer_wake    (timer_wake),
    .irq_wake      (irq_wake),
    .gie           (gie),
    .halted        (halted),
    .mode_key      (mode_key),
    .resume_pulse  (resume_pulse),
    .resume_vector (resume_vector),
    .halt_nop      (halt_nop),
    .illegal_op    (illegal_op),
    .halt_accept   (halt_accept),
    .wake_now      (wake_now)
  );
endmodule

// File: rtl/halt_ctrl_chk.sv
module halt_ctrl_chk #(
  parameter int N_TMR = 2,
  parameter int N_SRC = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             halt_strobe,
  input logic [3:0]       halt_operand,
  input logic [N_TMR-1:0] tmr_req,
  input logic [N_TMR-1:0] tmr_en,
  input logic [N_SRC-1:0] src_req,
  input logic [N_SRC-1:0] src_en,
  input logic             gie,
  input logic             halted,
  input logic             mode_key,
  input logic             key_release,
  input logic             resume_pulse,
  input logic             resume_vector,
  input logic             halt_nop,
  input logic             illegal_op
);
  logic no_enabled_req;
  assign no_enabled_req = ((tmr_req & tmr_en) == '0) && ((src_req & src_en) == '0);

  assert_illegal_is_nop_R2: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_op |-> halt_nop && !halted);

  assert_timer_flag_blocks_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!halted && halt_strobe && halt_operand == 4'b0010 && tmr_req != '0)
    |=> halt_nop && !halted);

  assert_nop_never_halted_R6: assert property (@(posedge clk) disable iff (!rst_n)
    halt_nop |-> !halted);

  assert_key_resume_next_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (halted && mode_key && key_release && no_enabled_req)
    |=> resume_pulse && !resume_vector);

  assert_disabled_req_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (halted && mode_key && !key_release && no_enabled_req) |=> halted);

  assert_vector_needs_gie_R9: assert property (@(posedge clk) disable iff (!rst_n)
    resume_vector |-> resume_pulse && $past(gie));

  assert_timer_mode_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (halted && !mode_key && (tmr_req & tmr_en) == '0) |=> halted);

  assert_pulse_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
    resume_pulse |=> !resume_pulse);

  assert_pulse_drops_halt_R11: assert property (@(posedge clk) disable iff (!rst_n)
    resume_pulse |-> !halted);

  assert_strobe_ignored_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (halted && halt_strobe) |=> !halt_nop && !illegal_op);
endmodule

bind halt_ctrl halt_ctrl_chk #(.N_TMR(N_TMR), .N_SRC(N_SRC)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .halt_strobe   (halt_strobe),
  .halt_operand  (halt_operand),
  .tmr_req       (tmr_req),
  .tmr_en        (tmr_en),
  .src_req       (src_req),
  .src_en        (src_en),
  .gie           (gie),
  .halted        (halted),
  .mode_key      (mode_key),
  .key_release   (key_release),
  .resume_pulse  (resume_pulse),
  .resume_vector (resume_vector),
  .halt_nop      (halt_nop),
  .illegal_op    (illegal_op)
);

// File: tb/sim_halt_ctrl.sv
module sim_halt_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int N_TMR = 2;
  localparam int N_SRC = 3;
  localparam int N_KF  = 8;
  localparam int N_KP  = 4;

  typedef struct packed {
    logic [3:0] op;
    logic [1:0] treq;
    logic [1:0] ten;
    logic [2:0] sreq;
    logic [2:0] sen;
    logic [7:0] kf;
    logic [7:0] kfu;
    logic [3:0] kp;
    logic [3:0] kpu;
    logic [3:0] kpl;
    logic       exp_h;
    logic       exp_nop;
    logic       exp_ill;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t TBL [NV] = '{
    '{4'h2, 2'b00, 2'b00, 3'b000, 3'b000, 8'hFF, 8'hFF, 4'h0, 4'hF, 4'hF, 1'b1, 1'b0, 1'b0}, // R6 timer ok
    '{4'h2, 2'b01, 2'b00, 3'b000, 3'b000, 8'hFF, 8'hFF, 4'h0, 4'hF, 4'hF, 1'b0, 1'b1, 1'b0}, // R3
    '{4'h8, 2'b00, 2'b00, 3'b000, 3'b000, 8'hFF, 8'hFF, 4'h0, 4'hF, 4'hF, 1'b1, 1'b0, 1'b0}, // R6 key ok
    '{4'h8, 2'b00, 2'b00, 3'b001, 3'b000, 8'hFF, 8'hFF, 4'h0, 4'hF, 4'hF, 1'b1, 1'b0, 1'b0}, // R4 disabled
    '{4'h8, 2'b00, 2'b00, 3'b010, 3'b010, 8'hFF, 8'hFF, 4'h0, 4'hF, 4'hF, 1'b0, 1'b1, 1'b0}, // R4 src
    '{4'h8, 2'b10, 2'b10, 3'b000, 3'b000, 8'hFF, 8'hFF, 4'h0, 4'hF, 4'hF, 1'b0, 1'b1, 1'b0}, // R4 timer
    '{4'h8, 2'b00, 2'b00, 3'b000, 3'b000, 8'hFE, 8'hFF, 4'h0, 4'hF, 4'hF, 1'b0, 1'b1, 1'b0}, // R5 fixed
    '{4'h8, 2'b00, 2'b00, 3'b000, 3'b000, 8'hFE, 8'hFE, 4'h0, 4'hF, 4'hF, 1'b1, 1'b0, 1'b0}, // R5 unused
    '{4'h8, 2'b00, 2'b00, 3'b000, 3'b000, 8'hFF, 8'hFF, 4'hD, 4'hF, 4'h3, 1'b0, 1'b1, 1'b0}, // R5 prog
    '{4'h8, 2'b00, 2'b00, 3'b000, 3'b000, 8'hFF, 8'hFF, 4'hC, 4'hF, 4'h3, 1'b1, 1'b0, 1'b0}, // R5 prog ok
    '{4'h0, 2'b00, 2'b00, 3'b000, 3'b000, 8'hFF, 8'hFF, 4'h0, 4'hF, 4'hF, 1'b0, 1'b1, 1'b1}, // R2
    '{4'hF, 2'b00, 2'b00, 3'b000, 3'b000, 8'hFF, 8'hFF, 4'h0, 4'hF, 4'hF, 1'b0, 1'b1, 1'b1}, // R2
    '{4'h4, 2'b00, 2'b00, 3'b000, 3'b000, 8'hFF, 8'hFF, 4'h0, 4'hF, 4'hF, 1'b0, 1'b1, 1'b1}, // R2
    '{4'h2, 2'b00, 2'b00, 3'b111, 3'b111, 8'hFF, 8'hFF, 4'h0, 4'hF, 4'hF, 1'b1, 1'b0, 1'b0}  // R10 entry
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic halt_strobe = 1'b0;
  logic [3:0] halt_operand = 4'h0;
  logic [N_TMR-1:0] tmr_req = '0, tmr_en = '0;
  logic [N_SRC-1:0] src_req = '0, src_en = '0;
  logic gie = 1'b0;
  logic [N_KF-1:0] kf_in = '1, kf_used = '1;
  logic [N_KP-1:0] kp_in = '0, kp_used = '1, kp_level = '1;
  logic halted, resume_pulse, resume_vector, halt_nop, illegal_op;

  int checks = 0;
  int errors = 0;
  logic done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  halt_ctrl #(.N_TMR(N_TMR), .N_SRC(N_SRC), .N_KF(N_KF), .N_KP(N_KP)) u0 (
    .clk(clk), .rst_n(rst_n), .halt_strobe(halt_strobe), .halt_operand(halt_operand),
    .tmr_req(tmr_req), .tmr_en(tmr_en), .src_req(src_req), .src_en(src_en), .gie(gie),
    .kf_in(kf_in), .kf_used(kf_used), .kp_in(kp_in), .kp_used(kp_used), .kp_level(kp_level),
    .halted(halted), .resume_pulse(resume_pulse), .resume_vector(resume_vector),
    .halt_nop(halt_nop), .illegal_op(illegal_op)
  );

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    halt_strobe = 1'b0; halt_operand = 4'h0;
    tmr_req = '0; tmr_en = '0; src_req = '0; src_en = '0; gie = 1'b0;
    kf_in = '1; kf_used = '1; kp_in = '0; kp_used = '1; kp_level = '1;
  endtask

  task automatic do_reset();
    idle_inputs();
    rst_n = 1'b0;
    tick(); tick();
    rst_n = 1'b1;
    tick(); tick(); tick();
  endtask

  task automatic strobe(input logic [3:0] op);
    halt_operand = op;
    halt_strobe = 1'b1;
    tick();
    halt_strobe = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    // R1: reset state
    tick();
    check("R1 halted", halted, 0);
    check("R1 resume_pulse", resume_pulse, 0);
    check("R1 resume_vector", resume_vector, 0);
    check("R1 halt_nop", halt_nop, 0);
    check("R1 illegal_op", illegal_op, 0);

    for (int i = 0; i < NV; i++) begin
      do_reset();
      tmr_req = TBL[i].treq; tmr_en = TBL[i].ten;
      src_req = TBL[i].sreq; src_en = TBL[i].sen;
      kf_in = TBL[i].kf; kf_used = TBL[i].kfu;
      kp_in = TBL[i].kp; kp_used = TBL[i].kpu; kp_level = TBL[i].kpl;
      tick(); tick(); tick();  // R13: let the synchronizer settle
      strobe(TBL[i].op);
      check($sformatf("R6/R3/R4/R5 vec%0d halted", i), halted, TBL[i].exp_h);
      check($sformatf("R2/R3/R4/R5 vec%0d nop", i), halt_nop, TBL[i].exp_nop);
      check($sformatf("R2 vec%0d illegal", i), illegal_op, TBL[i].exp_ill);
      tick();
      check($sformatf("R2 vec%0d nop one cycle", i), halt_nop, 0);
    end

    // R7 R13 R11: key release in key-wake mode, EI set
    do_reset();
    gie = 1'b1;
    strobe(4'h8);
    check("R6 key halt", halted, 1);
    kf_in = 8'hF7;
    tick(); tick();
    check("R13 not yet released", halted, 1);
    check("R13 no early pulse", resume_pulse, 0);
    tick();
    check("R7 pulse", resume_pulse, 1);
    check("R7 vector zero under EI", resume_vector, 0);
    check("R11 halted drops", halted, 0);
    tick();
    check("R11 pulse one cycle", resume_pulse, 0);

    // R8 R9: disabled request holds, enabled request under EI vectors
    do_reset();
    gie = 1'b1;
    strobe(4'h8);
    src_req = 3'b100;
    tick(); tick(); tick();
    check("R8 disabled request holds halt", halted, 1);
    check("R8 no pulse", resume_pulse, 0);
    // R12: strobe while halted
    strobe(4'h5);
    check("R12 no nop", halt_nop, 0);
    check("R12 no illegal", illegal_op, 0);
    check("R12 still halted", halted, 1);
    src_en = 3'b100;
    tick();
    check("R9 EI pulse", resume_pulse, 1);
    check("R9 EI vector", resume_vector, 1);
    check("R9 halted drops", halted, 0);

    // R9: DI resumes at next instruction
    do_reset();
    strobe(4'h8);
    tmr_en = 2'b01; tmr_req = 2'b01;
    tick();
    check("R9 DI pulse", resume_pulse, 1);
    check("R9 DI vector", resume_vector, 0);

    // R9: simultaneous key and enabled interrupt under EI -> vector
    do_reset();
    gie = 1'b1;
    strobe(4'h8);
    kf_in = 8'hFE;
    tick(); tick();
    src_en = 3'b001; src_req = 3'b001;
    tick();
    check("R9 combined pulse", resume_pulse, 1);
    check("R9 combined vector", resume_vector, 1);

    // R10: timer-wake mode ignores keys and other sources
    do_reset();
    gie = 1'b1;
    strobe(4'h2);
    check("R6 timer halt", halted, 1);
    kf_in = 8'h00;
    src_req = 3'b111; src_en = 3'b111;
    tmr_req = 2'b10; tmr_en = 2'b01;
    tick(); tick(); tick(); tick();
    check("R10 still halted", halted, 1);
    check("R8 disabled timer no pulse", resume_pulse, 0);
    tmr_en = 2'b11;
    tick();
    check("R10 timer wake pulse", resume_pulse, 1);
    check("R10 EI vector", resume_vector, 1);

    // R10 R9: timer wake under DI
    do_reset();
    strobe(4'h2);
    tmr_req = 2'b01; tmr_en = 2'b01;
    tick();
    check("R10 DI pulse", resume_pulse, 1);
    check("R9 DI timer vector", resume_vector, 0);
    check("R11 timer halted drops", halted, 0);

    // R13: entry uses synchronized keys (release level just removed)
    do_reset();
    kf_in = 8'h7F;
    tick(); tick(); tick();
    kf_in = 8'hFF;
    strobe(4'h8);
    check("R13 stale sync refuses", halt_nop, 1);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule